// File: doc/BRIEF.md
# Rotating Key Slot Store

This block keeps a one-byte secret key in a small private region of six byte-wide slots. It moves the key from one slot to the next on a timer, so that no storage cell holds the same key bit for long. After the key has been written into its new slot, every other slot is overwritten with a checkerboard filler byte. The filler inverts on each move. A three-bit offset register always names the slot that holds the key, and the key output reads through that offset.

Software or a key manager loads the key through a one-cycle load strobe and sets the move interval N in cycles. The crypto consumer reads the key continuously from the key output. The region is modelled as registers inside the block. A raw slot read port shows the region's contents, so that the filler and the migration can be observed.

A move takes eight cycles: one to read the key into a holding register, one to write it to the next slot and advance the offset, and six to sweep the filler over the slots. The interval counter counts only while no move is running.

Top module: `key_slot_rotator`

## Requirements
- R1: After reset, every slot holds 0, the key offset is 0 and the key output is 0.
- R2: A load strobe writes the key into slot 0, sets the offset to 0 and makes the key output equal the new key after the loading edge. This applies in any state, including in the middle of a move.
- R3: With a non-zero interval N, the offset advances exactly N+2 clock edges after a load, and again every N+8 edges after that.
- R4: After a move, the slot named by the new offset holds the key byte unchanged.
- R5: The first move after a load writes filler 8'hAA (bit 7 is 1, and the bits alternate down to bit 0, which is 0) into every slot except the key slot. The sweep finishes 6 edges after the offset advances.
- R6: The filler alternates between moves: 8'hAA, then 8'h55, then 8'hAA, and so on.
- R7: The offset counts 0, 1, 2, 3, 4, 5 and then wraps back to 0.
- R8: The key output equals the loaded key on every cycle, including every cycle of a move.
- R9: A load that lands during a move aborts that move and resets the filler phase, so the next move fills with 8'hAA.
- R10: An interval of 0 stops all moves. The offset stays where it is.
- R11: The raw read port returns the addressed slot combinationally, and returns 0 for an address of 6 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| keyLoadValid | input | 1 | One-cycle strobe that loads a new key |
| keyLoadData | input | KEY_W | Key byte to load |
| periodCfg | input | PERIOD_W | Move interval N in idle cycles; 0 disables moves |
| rawAddr | input | 3 | Slot address for the raw read port |
| keyOut | output | KEY_W | Current key |
| keyOffset | output | 3 | Slot that holds the key |
| rawData | output | KEY_W | Contents of the addressed slot |

## Verification
Each result is counted in clock edges from the loading edge. The offset is still 0 after N+1 edges and moves at edge N+2. The filler sweep is complete at edge N+8, and every later move lands N+8 edges after the one before it. The bench advances time with an edge-counting task and samples 1 ns after the edge, so each check reads its value at exactly the computed edge. Slot contents are read through the raw port only while the block is idle between moves. The key output is sampled on every cycle across two whole moves.

// File: rtl/keymove_pkg.sv
package keymove_pkg;
  localparam int unsigned KM_SLOTS = 6;
  localparam int unsigned KM_IDX_W = $clog2(KM_SLOTS);

  typedef struct packed {
    logic                capture;
    logic                writeKey;
    logic                fillWr;
    logic [KM_IDX_W-1:0] fillAddr;
    logic                endMove;
  } kmCtl_t;
endpackage

// File: rtl/keymove_ctrl.sv
module keymove_ctrl
  import keymove_pkg::*;
#(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                keyLoadValid,
  input  logic [PERIOD_W-1:0] periodCfg,
  output kmCtl_t              ctl
);
  localparam logic [PERIOD_W-1:0] CNT_ONE  = 1;
  localparam logic [KM_IDX_W-1:0] IDX_ONE  = 1;
  localparam logic [KM_IDX_W-1:0] IDX_LAST = KM_IDX_W'(KM_SLOTS - 1);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_FILL} mvState_t;

  mvState_t            state;
  logic [PERIOD_W-1:0] idleCnt;
  logic [KM_IDX_W-1:0] fillIdx;
  logic                expire;

  assign expire = (state == S_IDLE) && (periodCfg != '0) && ((idleCnt + CNT_ONE) == periodCfg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      idleCnt <= '0;
      fillIdx <= '0;
    end else if (keyLoadValid) begin
      state   <= S_IDLE;
      idleCnt <= '0;
      fillIdx <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (expire) begin
            state   <= S_READ;
            idleCnt <= '0;
          end else begin
            idleCnt <= idleCnt + CNT_ONE;
          end
        end
        S_READ:  state <= S_WRITE;
        S_WRITE: begin
          state   <= S_FILL;
          fillIdx <= '0;
        end
        S_FILL: begin
          if (fillIdx == IDX_LAST) begin
            state   <= S_IDLE;
            fillIdx <= '0;
          end else begin
            fillIdx <= fillIdx + IDX_ONE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.capture  = (state == S_READ);
    ctl.writeKey = (state == S_WRITE);
    ctl.fillWr   = (state == S_FILL);
    ctl.fillAddr = fillIdx;
    ctl.endMove  = (state == S_FILL) && (fillIdx == IDX_LAST);
  end

  // R8: at most one memory operation per cycle
  p_one_op_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.capture, ctl.writeKey, ctl.fillWr}));

  // R3: read of the key is followed directly by its write
  p_read_then_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && !keyLoadValid) |=> ctl.writeKey);

  // R10: a zero interval never starts a move
  p_no_move_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && periodCfg == '0) |=> !ctl.capture);
endmodule

// File: rtl/keymove_path.sv
module keymove_path
  import keymove_pkg::*;
#(
  parameter int unsigned KEY_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                keyLoadValid,
  input  logic [KEY_W-1:0]    keyLoadData,
  input  kmCtl_t              ctl,
  input  logic [KM_IDX_W-1:0] rawAddr,
  output logic [KEY_W-1:0]    keyOut,
  output logic [KM_IDX_W-1:0] keyOffset,
  output logic [KEY_W-1:0]    rawData
);
  localparam logic [KM_IDX_W-1:0] IDX_ONE  = 1;
  localparam logic [KM_IDX_W-1:0] IDX_LAST = KM_IDX_W'(KM_SLOTS - 1);

  logic [KEY_W-1:0]    slots [KM_SLOTS];
  logic [KEY_W-1:0]    holdKey;
  logic [KM_IDX_W-1:0] tracker;
  logic [KM_IDX_W-1:0] nextOfs;
  logic                phase;
  logic                inMove;
  logic [KEY_W-1:0]    filler;

  // checkerboard: odd bit positions set in phase 0, inverted in phase 1
  always_comb begin
    for (int b = 0; b < int'(KEY_W); b++) begin
      filler[b] = (b % 2 == 1) ^ phase;
    end
  end

  assign nextOfs = (tracker == IDX_LAST) ? '0 : tracker + IDX_ONE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < int'(KM_SLOTS); i++) slots[i] <= '0;
      holdKey <= '0;
      tracker <= '0;
      phase   <= 1'b0;
      inMove  <= 1'b0;
    end else if (keyLoadValid) begin
      slots[0] <= keyLoadData;
      holdKey  <= keyLoadData;
      tracker  <= '0;
      phase    <= 1'b0;
      inMove   <= 1'b0;
    end else begin
      if (ctl.capture) begin
        holdKey <= slots[tracker];
        inMove  <= 1'b1;
      end
      if (ctl.writeKey) begin
        slots[nextOfs] <= holdKey;
        tracker        <= nextOfs;
      end
      if (ctl.fillWr && (ctl.fillAddr != tracker)) begin
        slots[ctl.fillAddr] <= filler;
      end
      if (ctl.endMove) begin
        phase  <= ~phase;
        inMove <= 1'b0;
      end
    end
  end

  assign keyOut    = inMove ? holdKey : slots[tracker];
  assign keyOffset = tracker;
  assign rawData   = (rawAddr < KM_IDX_W'(KM_SLOTS)) ? slots[rawAddr] : '0;

  // R7: offset stays inside the region
  p_offset_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    keyOffset < KM_IDX_W'(KM_SLOTS));

  // R3: a key write advances the offset by one with wrap
  p_offset_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.writeKey && !keyLoadValid) |=>
      keyOffset == (($past(keyOffset) == IDX_LAST) ? '0 : $past(keyOffset) + IDX_ONE));

  // R4: the new key slot holds the held key
  p_key_lands_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.writeKey && !keyLoadValid) |=> slots[keyOffset] == $past(holdKey));

  // R8: key output steady through the filler sweep
  p_key_steady_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fillWr && !keyLoadValid) |=> keyOut == $past(keyOut));

  // R2: a load takes effect on the next cycle
  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    keyLoadValid |=> (keyOffset == '0) && (keyOut == $past(keyLoadData)));
endmodule

// File: rtl/key_slot_rotator.sv
module key_slot_rotator
  import keymove_pkg::*;
#(
  parameter int unsigned KEY_W    = 8,
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                keyLoadValid,
  input  logic [KEY_W-1:0]    keyLoadData,
  input  logic [PERIOD_W-1:0] periodCfg,
  input  logic [KM_IDX_W-1:0] rawAddr,
  output logic [KEY_W-1:0]    keyOut,
  output logic [KM_IDX_W-1:0] keyOffset,
  output logic [KEY_W-1:0]    rawData
);
  kmCtl_t ctl;

  keymove_ctrl #(.PERIOD_W(PERIOD_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .keyLoadValid (keyLoadValid),
    .periodCfg    (periodCfg),
    .ctl          (ctl)
  );

  keymove_path #(.KEY_W(KEY_W)) u_path (
    .clk          (clk),
    .rstN         (rstN),
    .keyLoadValid (keyLoadValid),
    .keyLoadData  (keyLoadData),
    .ctl          (ctl),
    .rawAddr      (rawAddr),
    .keyOut       (keyOut),
    .keyOffset    (keyOffset),
    .rawData      (rawData)
  );
endmodule

// File: tb/key_slot_rotator_tb.sv
`timescale 1ns/100ps
module key_slot_rotator_tb;
  localparam int N = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        keyLoadValid = 1'b0;
  logic [7:0]  keyLoadData = '0;
  logic [15:0] periodCfg = 16'(N);
  logic [2:0]  rawAddr = '0;
  logic [7:0]  keyOut;
  logic [2:0]  keyOffset;
  logic [7:0]  rawData;

  int checks = 0;
  int errs = 0;

  always #2.5 clk = ~clk;

  key_slot_rotator u_dut (
    .clk(clk), .rstN(rstN), .keyLoadValid(keyLoadValid), .keyLoadData(keyLoadData),
    .periodCfg(periodCfg), .rawAddr(rawAddr), .keyOut(keyOut),
    .keyOffset(keyOffset), .rawData(rawData)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic doLoad(input logic [7:0] k);
    keyLoadValid = 1'b1;
    keyLoadData  = k;
    tick(1);
    keyLoadValid = 1'b0;
  endtask

  // reads all slots through the raw port while the block is idle
  task automatic checkSlots(input string req, input int keyPos, input logic [7:0] key,
                            input logic [7:0] fill);
    for (int a = 0; a < 6; a++) begin
      rawAddr = 3'(a);
      #0.2;
      chk(req, rawData, (a == keyPos) ? key : fill);
    end
    rawAddr = '0;
  endtask

  task automatic t_reset();
    chk("R1 offset", keyOffset, 0);
    chk("R1 key", keyOut, 0);
    checkSlots("R1 slots", 0, 8'h00, 8'h00);
  endtask

  task automatic t_first_moves();
    doLoad(8'h5C);
    chk("R2 offset", keyOffset, 0);
    chk("R2 key", keyOut, 8'h5C);
    rawAddr = 3'd0; #0.2;
    chk("R2 slot0", rawData, 8'h5C);
    tick(N + 1);
    chk("R3 no early move", keyOffset, 0);
    tick(1);
    chk("R3 move at N+2", keyOffset, 1);
    tick(6);
    checkSlots("R4/R5 first fill", 1, 8'h5C, 8'hAA);
    tick(N + 1);
    chk("R3 no early second move", keyOffset, 1);
    tick(1);
    chk("R3 second move", keyOffset, 2);
    tick(6);
    checkSlots("R6 second fill", 2, 8'h5C, 8'h55);
    tick(N + 8);
    chk("R3 third move", keyOffset, 3);
    checkSlots("R6 third fill", 3, 8'h5C, 8'hAA);
  endtask

  task automatic t_wrap();
    doLoad(8'hE7);
    for (int m = 1; m <= 6; m++) begin
      tick(N + (m == 1 ? 2 : 8));
      chk("R7 offset seq", keyOffset, m % 6);
    end
    tick(6);
    checkSlots("R7 wrapped slots", 0, 8'hE7, 8'h55);
  endtask

  task automatic t_key_steady();
    int bad = 0;
    doLoad(8'h3C);
    for (int c = 0; c < 2 * N + 20; c++) begin
      if (keyOut != 8'h3C) bad++;
      tick(1);
    end
    chk("R8 key mismatches over two moves", bad, 0);
  endtask

  task automatic t_abort();
    doLoad(8'hA1);
    tick(N + 8);
    chk("R9 pre offset", keyOffset, 1);
    tick(N + 4);
    chk("R9 mid-move offset", keyOffset, 2);
    doLoad(8'hB2);
    chk("R9 abort offset", keyOffset, 0);
    chk("R9 abort key", keyOut, 8'hB2);
    tick(N + 8);
    chk("R9 next move offset", keyOffset, 1);
    checkSlots("R9 phase reset fill", 1, 8'hB2, 8'hAA);
  endtask

  task automatic t_period_off();
    periodCfg = '0;
    doLoad(8'h77);
    tick(4 * N);
    chk("R10 no move", keyOffset, 0);
    chk("R10 key", keyOut, 8'h77);
    periodCfg = 16'(N);
    doLoad(8'h77);
    tick(N + 2);
    chk("R10 moves resume", keyOffset, 1);
  endtask

  task automatic t_raw_oob();
    rawAddr = 3'd6; #0.2;
    chk("R11 addr 6", rawData, 0);
    rawAddr = 3'd7; #0.2;
    chk("R11 addr 7", rawData, 0);
    rawAddr = 3'd0;
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    t_reset();
    t_first_moves();
    t_wrap();
    t_key_steady();
    t_abort();
    t_period_off();
    t_raw_oob();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule